// File: doc/BRIEF.md
# Edge-Comparing Phase/Frequency Detector with Lock Flag

This block sits in the digital half of a frequency synthesizer loop. It watches two pulse trains, a reference train derived from the oscillator and a feedback train taken from the divided-down VCO. It reports which train's rising edge came first and holds that report until the other train's edge arrives. The report drives a three-state control pin through a separate drive-enable. The pin is pushed high when feedback lags the reference, meaning its frequency is too low. It is pushed low when feedback leads, meaning its frequency is too high. It floats when the two edges line up. The length of each drive pulse follows the phase error.

Both inputs pass through a configurable synchronizer. Only rising edges are used, so a pulse of any width counts once. When a reference edge and a feedback edge land in the same clock, they are taken as aligned and nothing is driven. An active-low lock flag goes low for the whole of every error interval. In a settled loop it therefore stays high, and it pulses low whenever the loop slips.

Top module: `phase_comparator`

## Requirements
- R1: While reset is high and in the cycle after it, drive_en is 0, drive_val is 0 and lock_n is 1.
- R2: A reference rising edge with no pending feedback error sets the "feedback late" state: drive_en=1 and drive_val=1 from the next clock until a feedback rising edge is seen.
- R3: A feedback rising edge with no pending reference error sets the "feedback early" state: drive_en=1 and drive_val=0 until a reference rising edge is seen.
- R4: An edge on the lagging input ends the error interval: one clock after it, drive_en=0. The drive pulse is therefore as long, in clocks, as the edge separation.
- R5: Reference and feedback rising edges that arrive in the same clock are coincident. No error state is entered, drive_en stays 0 and lock_n stays 1.
- R6: lock_n is low in exactly the cycles in which drive_en is high. It is therefore low for at least one clock per error interval.
- R7: A change on ref_pulse or fb_pulse reaches the outputs SYNC_STAGES+1 clocks later.
- R8: Only low-to-high transitions count. An input held high for several clocks acts as a single edge.
- R9: drive_val is 0 whenever drive_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Reference pulse train |
| fb_pulse | input | 1 | Divided feedback pulse train |
| drive_val | output | 1 | Value for the three-state pad: 1 means raise the VCO, 0 means lower it |
| drive_en | output | 1 | Pad drive enable; 0 means the pad floats |
| lock_n | output | 1 | Lock flag, low during every error interval |

## Verification
A stuck or wrongly cleared error flag shows up at the ports as a drive_en run that does not end one clock after the lagging edge. A stale flag also shows up the next time the opposite input leads, because drive_val then has the wrong polarity. A flag set on coincident edges becomes visible SYNC_STAGES+1 clocks after the aligned pulses, as a one-cycle drop of lock_n. A cycle-by-cycle comparison against an edge-level model exposes all of these within one reference period. Wrong synchronizer depth, or edge detection that responds to a level instead of an edge, shifts or stretches every interval and is caught in the same way.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic ref_lead;
        logic fb_lead;
    } err_flags_t;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'd0,
        DRV_HIGH  = 2'd1,
        DRV_LOW   = 2'd2
    } drive_e;

    function automatic drive_e classify(err_flags_t f);
        if (f.ref_lead && !f.fb_lead) return DRV_HIGH;
        if (f.fb_lead && !f.ref_lead) return DRV_LOW;
        return DRV_FLOAT;
    endfunction

endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [SYNC_STAGES:0] chain;
    logic                 last;

    assign chain[0] = raw_in;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) chain[i+1] <= 1'b0;
                else     chain[i+1] <= chain[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[SYNC_STAGES];
    end

    assign rise = chain[SYNC_STAGES] & ~last;
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_rise,
    input  logic       fb_rise,
    output err_flags_t flags
);
    err_flags_t nxt;

    always_comb begin
        nxt.ref_lead = flags.ref_lead | ref_rise;
        nxt.fb_lead  = flags.fb_lead  | fb_rise;
        if (nxt.ref_lead && nxt.fb_lead) nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
    import pfd_pkg::*;
(
    input  err_flags_t flags,
    output logic       drive_val,
    output logic       drive_en,
    output logic       lock_n
);
    drive_e mode;

    always_comb begin
        mode      = classify(flags);
        drive_en  = (mode != DRV_FLOAT);
        drive_val = (mode == DRV_HIGH);
        lock_n    = (mode == DRV_FLOAT);
    end
endmodule

// File: rtl/phase_comparator.sv
module phase_comparator
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic drive_val,
    output logic drive_en,
    output logic lock_n
);
    logic       ref_rise;
    logic       fb_rise;
    err_flags_t flags;

    pfd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
        .clk(clk), .rst(rst), .raw_in(ref_pulse), .rise(ref_rise)
    );

    pfd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
        .clk(clk), .rst(rst), .raw_in(fb_pulse), .rise(fb_rise)
    );

    pfd_flag_core u_core (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise), .flags(flags)
    );

    pfd_out_stage u_out (
        .flags(flags), .drive_val(drive_val), .drive_en(drive_en), .lock_n(lock_n)
    );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
    input logic clk,
    input logic rst,
    input logic ref_rise,
    input logic fb_rise,
    input logic drive_val,
    input logic drive_en,
    input logic lock_n
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!drive_en && lock_n && !drive_val)); // R1
    AST_REF_LEADS: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && !fb_rise && !(drive_en && !drive_val)) |=> (drive_en && drive_val)); // R2
    AST_FB_LEADS: assert property (@(posedge clk) disable iff (rst)
        (fb_rise && !ref_rise && !(drive_en && drive_val)) |=> (drive_en && !drive_val)); // R3
    AST_LAG_CLEARS_UP: assert property (@(posedge clk) disable iff (rst)
        (drive_en && drive_val && fb_rise) |=> !drive_en); // R4
    AST_LAG_CLEARS_DN: assert property (@(posedge clk) disable iff (rst)
        (drive_en && !drive_val && ref_rise) |=> !drive_en); // R4
    AST_COINCIDENT: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise && !drive_en) |=> !drive_en); // R5
    AST_LOCK_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        lock_n == !drive_en); // R6
    AST_FLOAT_VAL_LOW: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> !drive_val); // R9
endmodule

bind phase_comparator pfd_checker u_chk (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .drive_val(drive_val), .drive_en(drive_en), .lock_n(lock_n)
);

// File: tb/tb_phase_comparator.sv
module tb_phase_comparator;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0;
    logic fb_pulse  = 1'b0;
    logic drive_val, drive_en, lock_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_comparator #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .drive_val(drive_val), .drive_en(drive_en), .lock_n(lock_n)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {en,val,lock_n} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int up_cyc, dn_cyc, max_run;

    // Run one segment: ref period pr, feedback period pf, phase offsets.
    task automatic run_seg(input int pr, input int pf, input int roff, input int foff, input int steps);
        logic [1:0] ring [0:7];
        logic mu = 0, md = 0, rp = 0, fp = 0;
        int run = 0;
        up_cyc = 0; dn_cyc = 0; max_run = 0;
        rst = 1'b1; ref_pulse = 1'b0; fb_pulse = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {drive_en, drive_val, lock_n}, 3'b001);
        rst = 1'b0;
        for (int t = 0; t < steps; t++) begin
            logic [1:0] e;
            logic r, f, re, fe, nu, nd;
            @(negedge clk);
            e = (t >= LAT) ? ring[(t - LAT) % 8] : 2'b00;
            if (t == 0) check("R1", {drive_en, drive_val, lock_n}, 3'b001);
            check("R7 R8", {drive_en, drive_val, lock_n}, {e[1] ^ e[0], e[1], ~(e[1] | e[0])});
            check("R6 R9", {drive_en, drive_val, lock_n},
                  {drive_en, drive_val & drive_en, ~drive_en});
            if (drive_en && drive_val) up_cyc++;
            if (drive_en && !drive_val) dn_cyc++;
            run = drive_en ? run + 1 : 0;
            if (run > max_run) max_run = run;
            r = ((t + roff) % pr) < 2;
            f = ((t + foff) % pf) < 2;
            ref_pulse = r; fb_pulse = f;
            re = r & ~rp; fe = f & ~fp; rp = r; fp = f;
            nu = mu | re; nd = md | fe;
            if (nu && nd) begin nu = 0; nd = 0; end
            mu = nu; md = nd;
            ring[t % 8] = {mu, md};
        end
    endtask

    initial begin
        // slow feedback: raise drive dominates
        run_seg(20, 23, 5, 5, 400);
        check_int("R2 slow fb drives high", up_cyc > 4 * dn_cyc, up_cyc, dn_cyc);
        // fast feedback: lower drive dominates
        run_seg(20, 17, 5, 5, 400);
        check_int("R3 fast fb drives low", dn_cyc > 4 * up_cyc, dn_cyc, up_cyc);
        // matched rate, same clock edges: coincident, never driven
        run_seg(20, 20, 5, 5, 400);
        check_int("R5 coincident edges float", (up_cyc + dn_cyc) == 0, up_cyc + dn_cyc, 0);
        // matched rate, feedback lagging by 3 clocks
        run_seg(20, 20, 5, 2, 400);
        check_int("R4 pulse width equals lag", max_run == 3, max_run, 3);
        check_int("R2 lag gives high drive only", dn_cyc == 0 && up_cyc > 0, dn_cyc, 0);
        // matched rate, feedback leading by 1 clock
        run_seg(20, 20, 5, 6, 400);
        check_int("R4 pulse width equals lead", max_run == 1, max_run, 1);
        check_int("R3 lead gives low drive only", up_cyc == 0 && dn_cyc > 0, up_cyc, 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule